// File: doc/BRIEF.md
# Reservation Station Scheduler with Producer Tags

This block issues arithmetic instructions into a small pool of reservation stations and runs them out of order as their operands arrive. Each instruction names an operation, two source registers and a destination register. At issue, every source is either copied from the register file or replaced by the tag of the station that will produce it. The destination register is then marked with the tag of the newly allocated station. Because operands are renamed this way, write-after-read and write-after-write hazards need no stall. The only issue stall is a structural one: no free station of the needed class.

Each station contains a fixed-latency execution model. It starts counting once both of its operands are present. Finished results leave over a single shared result bus that carries one tagged value per cycle. Waiting stations and the register file snoop this bus. A register accepts a broadcast only while its producer tag still names the broadcasting station. An observation port lets the surrounding logic read any register's value and pending tag.

Top module: `fp_tag_scheduler`

## Requirements
- R1: After synchronous reset, every station is free, every register's pending tag is 0, register r holds the value r, and the result bus is idle.
- R2: Operation codes 0 (add) and 1 (subtract) use the three short stations with tags 1 to 3. Codes 2 (multiply) and 3 (divide) use the two long stations with tags 4 and 5. `iss_ready` is high only while a station of the requested class is free. An instruction is taken on a clock edge where `iss_valid` and `iss_ready` are both high; otherwise it waits at the port.
- R3: At issue, a source whose register has pending tag 0 is captured as a value. Any other source keeps the pending tag. The destination register's pending tag becomes the allocated station's tag, visible on `obs_tag` from the next cycle.
- R4: If a source register's pending tag equals the tag on the result bus in the issue cycle, the bus value is captured instead of the register value.
- R5: A station starts its count only when both operands are present. A lone instruction with ready operands appears on the bus in the Lth cycle after its issue edge, with L = 2 for add/subtract, 4 for multiply and 6 for divide.
- R6: Results are 16 bits wide. Add and subtract wrap modulo 2^16, multiply keeps the low 16 bits, and divide gives the unsigned quotient, or 0xFFFF when the divisor is 0.
- R7: The bus carries at most one result per cycle. Every station waiting on that tag captures the value, so a dependent instruction computes with the producer's result.
- R8: A register takes a broadcast value, and clears its pending tag, only when its pending tag equals the broadcast tag. Otherwise the value is dropped and the later writer's result remains.
- R9: An instruction that captured a source value keeps it even if a later instruction rewrites that source register before the first one executes.
- R10: When several stations finish together, the lowest tag is broadcast first. Each loser keeps its result and is broadcast in a later cycle.
- R11: A station becomes free, and its destination's pending tag clears, on the edge that ends its broadcast cycle. A new instruction can take that station in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction present at the issue port |
| iss_op | input | 2 | Operation code: 0 add, 1 sub, 2 mul, 3 div |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| iss_dst | input | 4 | Destination register index |
| iss_ready | output | 1 | A station of the requested class is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 3 | Tag of the station broadcasting |
| cdb_value | output | 16 | Broadcast result value |
| obs_idx | input | 4 | Register selected for observation |
| obs_value | output | 16 | Value of the observed register |
| obs_tag | output | 3 | Pending producer tag of the observed register |

## Verification
Some behaviours are checked by assertions on every cycle. These are: the bus grant is one-hot, a station frees after its grant, and a station finishes only after both operand tags have cleared. Also checked: a losing station holds its result, a register whose tag does not match a broadcast keeps its value, and issue writes the destination tag. Other behaviours need whole instruction sequences, which only the bench scenarios show. These are the arithmetic results, exact broadcast cycles, same-cycle bus capture at issue, the dropped stale write under write-after-write, the preserved old operand under write-after-read, and the structural stall with its release.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int unsigned DW      = 16;
    localparam int unsigned NREG    = 16;
    localparam int unsigned RIDX    = $clog2(NREG);
    localparam int unsigned N_SHORT = 3;
    localparam int unsigned N_LONG  = 2;
    localparam int unsigned NST     = N_SHORT + N_LONG;
    localparam int unsigned TAGW    = $clog2(NST + 1);
    localparam int unsigned LAT_ADD = 2;
    localparam int unsigned LAT_MUL = 4;
    localparam int unsigned LAT_DIV = 6;
    localparam int unsigned CNTW    = $clog2(LAT_DIV);

    typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_DIV = 2'd3} op_e;
    typedef logic [TAGW-1:0] tag_t;
    typedef logic [DW-1:0]   word_t;

    typedef struct packed {
        op_e   op;
        tag_t  qj;
        tag_t  qk;
        word_t vj;
        word_t vk;
    } entry_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t value;
    } bus_t;

    typedef struct packed {
        tag_t  q;
        word_t v;
    } operand_t;

    function automatic word_t alu(op_e op, word_t a, word_t b);
        logic [2*DW-1:0] prod;
        prod = a * b;
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return prod[DW-1:0];
            default: return (b == '0) ? '1 : a / b;
        endcase
    endfunction

    function automatic logic [CNTW-1:0] last_count(op_e op);
        case (op)
            OP_MUL:  return CNTW'(LAT_MUL - 1);
            OP_DIV:  return CNTW'(LAT_DIV - 1);
            default: return CNTW'(LAT_ADD - 1);
        endcase
    endfunction
endpackage

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  entry_t in_entry,
    input  bus_t   bus,
    input  logic   grant,
    output logic   busy,
    output logic   req,
    output word_t  result
);
    entry_t          ent;
    logic            done;
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            ent    <= '0;
            result <= '0;
        end else if (load) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= '0;
            ent  <= in_entry;
        end else if (busy) begin
            if (grant) begin
                busy <= 1'b0;
                done <= 1'b0;
            end
            if (bus.valid && ent.qj != '0 && ent.qj == bus.tag) begin
                ent.vj <= bus.value;
                ent.qj <= '0;
            end
            if (bus.valid && ent.qk != '0 && ent.qk == bus.tag) begin
                ent.vk <= bus.value;
                ent.qk <= '0;
            end
            if (!done && ent.qj == '0 && ent.qk == '0) begin
                if (cnt == last_count(ent.op)) begin
                    done   <= 1'b1;
                    result <= alu(ent.op, ent.vj, ent.vk);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign req = done;

    assert_waits_operands_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ent.qj == '0 && ent.qk == '0));
    assert_loser_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !grant) |=> (done && $stable(result)));
    assert_free_after_grant_R11: assert property (@(posedge clk) disable iff (rst)
        grant |=> !busy);
endmodule

// File: rtl/rs_arbiter.sv
module rs_arbiter #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && grant == '0) grant[i] = 1'b1;
        end
    end

    assert_grant_served_R10: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> ((grant & req) != '0));
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/rs_regfile.sv
module rs_regfile
    import rs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_t            bus,
    input  logic            issue_we,
    input  logic [RIDX-1:0] issue_dst,
    input  tag_t            issue_tag,
    input  logic [RIDX-1:0] src_a,
    input  logic [RIDX-1:0] src_b,
    output operand_t        opnd_a,
    output operand_t        opnd_b,
    input  logic [RIDX-1:0] obs_idx,
    output word_t           obs_value,
    output tag_t            obs_tag
);
    word_t val [NREG];
    tag_t  qi  [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                val[r] <= word_t'(r);
                qi[r]  <= '0;
            end else begin
                if (bus.valid && qi[r] != '0 && qi[r] == bus.tag) begin
                    val[r] <= bus.value;
                    qi[r]  <= '0;
                end
                if (issue_we && issue_dst == RIDX'(r)) qi[r] <= issue_tag;
            end
        end

        assert_stale_drop_R8: assert property (@(posedge clk) disable iff (rst)
            (!bus.valid || qi[r] != bus.tag) |=> $stable(val[r]));
    end

    function automatic operand_t lookup(logic [RIDX-1:0] idx);
        operand_t o;
        if (qi[idx] == '0) begin
            o.q = '0;
            o.v = val[idx];
        end else if (bus.valid && bus.tag == qi[idx]) begin
            o.q = '0;
            o.v = bus.value;
        end else begin
            o.q = qi[idx];
            o.v = '0;
        end
        return o;
    endfunction

    assign opnd_a    = lookup(src_a);
    assign opnd_b    = lookup(src_b);
    assign obs_value = val[obs_idx];
    assign obs_tag   = qi[obs_idx];

    assert_dest_tagged_R3: assert property (@(posedge clk) disable iff (rst)
        issue_we |=> qi[$past(issue_dst)] == $past(issue_tag));
endmodule

// File: rtl/fp_tag_scheduler.sv
module fp_tag_scheduler
    import rs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [1:0]       iss_op,
    input  logic [RIDX-1:0]  iss_src_a,
    input  logic [RIDX-1:0]  iss_src_b,
    input  logic [RIDX-1:0]  iss_dst,
    output logic             iss_ready,
    output logic             cdb_valid,
    output logic [TAGW-1:0]  cdb_tag,
    output logic [DW-1:0]    cdb_value,
    input  logic [RIDX-1:0]  obs_idx,
    output logic [DW-1:0]    obs_value,
    output logic [TAGW-1:0]  obs_tag
);
    logic [NST-1:0] busy, req, grant, cand, alloc;
    word_t          res [NST];
    bus_t           bus;
    operand_t       opnd_a, opnd_b;
    entry_t         new_entry;
    tag_t           new_tag;
    logic           accept;
    op_e            op;

    assign op = op_e'(iss_op);

    for (genvar i = 0; i < NST; i++) begin : g_cand
        localparam bit LONG = (i >= N_SHORT);
        assign cand[i] = !busy[i] && (op[1] == LONG);
    end

    always_comb begin
        alloc   = '0;
        new_tag = '0;
        for (int i = 0; i < NST; i++) begin
            if (cand[i] && alloc == '0) begin
                alloc[i] = 1'b1;
                new_tag  = tag_t'(i + 1);
            end
        end
    end

    assign iss_ready = |cand;
    assign accept    = iss_valid && iss_ready;

    rs_regfile u_regs (
        .clk(clk), .rst(rst), .bus(bus),
        .issue_we(accept), .issue_dst(iss_dst), .issue_tag(new_tag),
        .src_a(iss_src_a), .src_b(iss_src_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .obs_idx(obs_idx), .obs_value(obs_value), .obs_tag(obs_tag)
    );

    assign new_entry = '{op: op, qj: opnd_a.q, qk: opnd_b.q, vj: opnd_a.v, vk: opnd_b.v};

    for (genvar i = 0; i < NST; i++) begin : g_st
        rs_station u_st (
            .clk(clk), .rst(rst),
            .load(accept && alloc[i]), .in_entry(new_entry),
            .bus(bus), .grant(grant[i]),
            .busy(busy[i]), .req(req[i]), .result(res[i])
        );
    end

    rs_arbiter #(.N(NST)) u_arb (.clk(clk), .rst(rst), .req(req), .grant(grant));

    always_comb begin
        bus = '0;
        for (int i = 0; i < NST; i++) begin
            if (grant[i]) begin
                bus.valid = 1'b1;
                bus.tag   = tag_t'(i + 1);
                bus.value = res[i];
            end
        end
    end

    assign cdb_valid = bus.valid;
    assign cdb_tag   = bus.tag;
    assign cdb_value = bus.value;

    assert_stall_no_alloc_R2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> $countones(busy) <= $past($countones(busy)));
endmodule

// File: tb/fp_tag_scheduler_test.sv
`timescale 1ns/1ps
module fp_tag_scheduler_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = 2'd0;
    logic [3:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0, obs_idx = '0;
    logic        iss_ready, cdb_valid;
    logic [2:0]  cdb_tag, obs_tag;
    logic [15:0] cdb_value, obs_value;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fp_tag_scheduler uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_value(cdb_value), .obs_idx(obs_idx), .obs_value(obs_value), .obs_tag(obs_tag)
    );

    // op[29:28] a[27:24] b[23:20] dst[19:16] expected[15:0]
    localparam logic [29:0] VEC [7] = '{
        {2'd0, 4'd1,  4'd2, 4'd8,  16'd3},
        {2'd1, 4'd7,  4'd3, 4'd9,  16'd4},
        {2'd2, 4'd5,  4'd6, 4'd10, 16'd30},
        {2'd3, 4'd14, 4'd4, 4'd11, 16'd3},
        {2'd3, 4'd5,  4'd0, 4'd12, 16'hFFFF},
        {2'd1, 4'd2,  4'd7, 4'd13, 16'hFFFB},
        {2'd0, 4'd8,  4'd9, 4'd15, 16'd7}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        iss_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a negedge; returns 1ns after the accepting edge.
    task automatic issue(logic [1:0] op, logic [3:0] a, logic [3:0] b, logic [3:0] d, output int stalls);
        stalls = 0;
        iss_op = op; iss_src_a = a; iss_src_b = b; iss_dst = d; iss_valid = 1'b1;
        #0.1;
        while (!iss_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        #1 iss_valid = 1'b0;
    endtask

    task automatic read_reg(logic [3:0] idx, output logic [15:0] v, output logic [2:0] t);
        obs_idx = idx;
        #0.5;
        v = obs_value;
        t = obs_tag;
    endtask

    task automatic drain();
        repeat (20) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st;
        int bad;
        logic [15:0] v;
        logic [2:0]  t;
        logic seen;

        // R1 reset state
        do_reset();
        iss_op = 2'd0;
        #0.1;
        check("R1 bus idle", cdb_valid, 0);
        check("R1 ready", iss_ready, 1);
        bad = 0;
        for (int r = 0; r < 16; r++) begin
            read_reg(4'(r), v, t);
            if (v != 16'(r) || t != 0) bad++;
        end
        check("R1 registers", bad, 0);

        // R6 vector table
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            issue(VEC[i][29:28], VEC[i][27:24], VEC[i][23:20], VEC[i][19:16], st);
            drain();
            read_reg(VEC[i][19:16], v, t);
            check($sformatf("R6 vector %0d", i), v, VEC[i][15:0]);
        end

        // R5 latency, R3 tag, R4 bus bypass at issue, R11 free and clear
        do_reset();
        issue(2'd0, 4'd1, 4'd2, 4'd4, st);
        @(negedge clk);                       // k=0
        read_reg(4'd4, v, t);
        check("R3 dest tag", t, 1);
        check("R5 no early bus k0", cdb_valid, 0);
        @(negedge clk);                       // k=1
        check("R5 no early bus k1", cdb_valid, 0);
        @(negedge clk);                       // k=2
        check("R5 add on bus", {cdb_valid, cdb_tag, cdb_value}, {1'b1, 3'd1, 16'd3});
        issue(2'd0, 4'd4, 4'd2, 4'd6, st);    // issues on the broadcast edge
        @(negedge clk);
        read_reg(4'd4, v, t);
        check("R11 tag cleared", t, 0);
        check("R8 value written", v, 3);
        drain();
        read_reg(4'd6, v, t);
        check("R4 bypass result", {v, 13'd0, t}, {16'd5, 16'd0});

        // R10 simultaneous finish: mul at E0, add at E2
        do_reset();
        issue(2'd2, 4'd3, 4'd4, 4'd1, st);
        @(negedge clk);                       // k=0
        @(negedge clk);                       // k=1
        issue(2'd0, 4'd5, 4'd6, 4'd2, st);
        @(negedge clk);                       // k=2
        @(negedge clk);                       // k=3
        @(negedge clk);                       // k=4
        check("R10 winner tag1", {cdb_valid, cdb_tag, cdb_value}, {1'b1, 3'd1, 16'd11});
        @(negedge clk);                       // k=5
        check("R10 loser next", {cdb_valid, cdb_tag, cdb_value}, {1'b1, 3'd4, 16'd12});

        // R7 dependent chain
        do_reset();
        issue(2'd2, 4'd3, 4'd4, 4'd1, st);
        @(negedge clk);
        issue(2'd0, 4'd1, 4'd2, 4'd5, st);
        drain();
        read_reg(4'd5, v, t);
        check("R7 consumer result", v, 14);

        // R8 write-after-write: slow div then fast add to same dest
        do_reset();
        issue(2'd3, 4'd14, 4'd7, 4'd6, st);
        @(negedge clk);
        issue(2'd0, 4'd1, 4'd2, 4'd6, st);
        seen = 1'b0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (cdb_valid && cdb_tag == 3'd4 && cdb_value == 16'd2) seen = 1'b1;
        end
        check("R8 div broadcast seen", seen, 1);
        read_reg(4'd6, v, t);
        check("R8 later writer kept", {v, 13'd0, t}, {16'd3, 16'd0});

        // R9 write-after-read
        do_reset();
        issue(2'd3, 4'd12, 4'd4, 4'd9, st);
        @(negedge clk);
        issue(2'd0, 4'd9, 4'd3, 4'd10, st);
        @(negedge clk);
        issue(2'd1, 4'd7, 4'd5, 4'd3, st);
        drain();
        read_reg(4'd10, v, t);
        check("R9 old operand used", v, 6);
        read_reg(4'd3, v, t);
        check("R9 rewrite done", v, 2);

        // R2 structural stall and R11 release
        do_reset();
        issue(2'd3, 4'd12, 4'd4, 4'd9, st);
        @(negedge clk);
        issue(2'd0, 4'd9, 4'd1, 4'd1, st);
        @(negedge clk);
        issue(2'd0, 4'd9, 4'd2, 4'd2, st);
        @(negedge clk);
        issue(2'd0, 4'd9, 4'd3, 4'd3, st);
        @(negedge clk);
        iss_op = 2'd0;
        #0.1;
        check("R2 short class full", iss_ready, 0);
        iss_op = 2'd2;
        #0.1;
        check("R2 long class free", iss_ready, 1);
        issue(2'd0, 4'd1, 4'd2, 4'd5, st);
        check("R2 stalled then taken", st > 0, 1);
        drain();
        read_reg(4'd5, v, t);
        check("R11 reused station result", v, 9);
        read_reg(4'd3, v, t);
        check("R7 fan-out result", v, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule